// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block collects up to 32 interrupt request lines and presents them to a processor as one interrupt output plus a small set of 32-bit registers on a single-cycle bus. Each line is fixed at build time as either edge-triggered or level-sensitive. Requests are latched into a status register, and a separate enable register masks them. Software services interrupts by reading a vector register that names the most urgent pending, enabled line. It then acknowledges that line by writing a one to its bit.

The enable register can be written whole. Dedicated set and clear words also change single enable bits without a read-modify-write. A two-bit control word gates the processor output and the hardware capture path. While hardware capture is still off, software may inject requests by writing the status word, which allows test interrupts.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears status, enable and control registers. Afterwards the vector word reads 0xFFFFFFFF and irq_o is low.
- R2: A write at byte offset 0x08 loads the enable register. A write at 0x10 ORs its one bits into enable. A write at 0x14 clears the enable bits where the data has ones. All other enable bits keep their values.
- R3: An input whose bit in EDGE_MASK is one sets its status bit on the clock after a 0-to-1 change. A line held high after its acknowledge does not set the bit again.
- R4: An input whose bit in EDGE_MASK is zero sets its status bit on each clock where it is high. If an acknowledge clears the bit while the line is still high, the bit is set again on the following clock. If the line is low, the bit stays clear.
- R5: Writing at offset 0x0C clears each status bit where the data has a one, and wins over a capture on the same clock. Zero bits have no effect, and 0xFFFFFFFF clears every bit.
- R6: Offset 0x04 reads the status bits ANDed with the enable bits.
- R7: Offset 0x18 reads the index of the lowest-numbered bit that is set at 0x04, so lower numbers have priority. It reads 0xFFFFFFFF when no bit is set.
- R8: Offset 0x1C holds the control word, where bit 0 is the output enable and bit 1 is the hardware capture enable. Inputs are latched only while bit 1 is one. irq_o is high exactly when bit 0 is one and any bit is set at 0x04.
- R9: While control bit 1 is zero, a write at offset 0x00 ORs its data into status. While that bit is one, such writes are ignored.
- R10: Reads of 0x0C, 0x10, 0x14 and of any unmapped address return zero, and writes to unmapped addresses change nothing. Register bits at and above NUM_SRC read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk_i |
| addr_i | input | 32 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one write per clock |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- A level line still high when its acknowledge arrives must come back one clock later. A design that let the capture win over the clear would never appear to acknowledge. One that latched only once would lose the request.
- An edge line held high must stay cleared after its acknowledge. A design that treated it as level would re-raise forever.
- Priority is checked with two pending lines, and the empty vector is checked for 0xFFFFFFFF. A wrong scan direction or a zero default would return the wrong index.
- The control bits are checked separately. Latching with capture off, writing status with capture on, or raising irq_o without the output enable each yield a wrong status read or output level.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int BUS_W = 32;

  // word index = byte address [4:2]
  typedef enum logic [2:0] {
    W_STAT  = 3'd0,
    W_PEND  = 3'd1,
    W_ENAB  = 3'd2,
    W_ACK   = 3'd3,
    W_SETEN = 3'd4,
    W_CLREN = 3'd5,
    W_VEC   = 3'd6,
    W_CTRL  = 3'd7
  } reg_word_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               hw_en_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] status_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (EDGE_MASK[k]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i[k];
      end
      assign hit[k] = src_i[k] & ~prev_q;

      // R3
      edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_en_i && src_i[k] && !prev_q && !clr_i[k]) |=> status_q[k]);
    end else begin : g_level
      assign hit[k] = src_i[k];

      // R4
      level_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_en_i && src_i[k] && !clr_i[k]) |=> status_q[k]);
    end
  end

  // clear wins over a same-cycle capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q | ({NUM_SRC{hw_en_i}} & hit) | sw_set_i) & ~clr_i;
  end

  assign status_o = status_q;

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_q & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  // scan downward so the lowest set index is the last assignment
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [BUS_W-1:0]   addr_i,
  input  logic               wr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               hit_map;
  reg_word_e          word;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] enable_q;
  logic [1:0]         ctrl_q;
  logic [NUM_SRC-1:0] status_w;
  logic [NUM_SRC-1:0] pending_w;
  logic [NUM_SRC-1:0] sw_set_w;
  logic [NUM_SRC-1:0] clr_w;
  logic               vec_valid;
  logic [IDX_W-1:0]   vec_idx;
  logic               stat_wr;

  assign hit_map = (addr_i[31:5] == '0) && (addr_i[1:0] == 2'b00);
  assign word    = reg_word_e'(addr_i[4:2]);
  assign wbits   = wdata_i[NUM_SRC-1:0];
  assign stat_wr = wr_i && hit_map && (word == W_STAT);

  assign sw_set_w = (stat_wr && !ctrl_q[1]) ? wbits : '0;
  assign clr_w    = (wr_i && hit_map && (word == W_ACK)) ? wbits : '0;

  irq_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .hw_en_i  (ctrl_q[1]),
    .sw_set_i (sw_set_w),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      ctrl_q   <= 2'b00;
    end else if (wr_i && hit_map) begin
      case (word)
        W_ENAB:  enable_q <= wbits;
        W_SETEN: enable_q <= enable_q | wbits;
        W_CLREN: enable_q <= enable_q & ~wbits;
        W_CTRL:  ctrl_q   <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  assign pending_w = status_w & enable_q;

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
    .req_i   (pending_w),
    .valid_o (vec_valid),
    .idx_o   (vec_idx)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_map) begin
      case (word)
        W_STAT:  rdata_o = BUS_W'(status_w);
        W_PEND:  rdata_o = BUS_W'(pending_w);
        W_ENAB:  rdata_o = BUS_W'(enable_q);
        W_VEC:   rdata_o = vec_valid ? BUS_W'(vec_idx) : '1;
        W_CTRL:  rdata_o = BUS_W'(ctrl_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = ctrl_q[0] & (|pending_w);

  // R2
  set_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_map && word == W_SETEN) |=> ((enable_q & $past(wbits)) == $past(wbits)));

  // R7
  vec_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid |-> (pending_w[vec_idx] && ((pending_w & ~({NUM_SRC{1'b1}} << vec_idx)) == '0)));

  // R7
  vec_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid |-> (pending_w == '0));

  // R8
  no_hw_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[1] && !stat_wr) |=> ((status_w & ~$past(status_w)) == '0));

  // R9
  stat_wr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[1] && stat_wr) |-> (sw_set_w == '0));

  logic unused_bits;
  assign unused_bits = ^{wdata_i, addr_i};
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  localparam int NSRC = 8;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  src;
    logic [7:0]  chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  // inputs 0..3 edge, 4..7 level
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h00, 32'h05, 8'h00, 8'h00, 32'h05, 8'd9},        // R9 sw set, capture off
    '{1'b1, 8'h10, 32'h04, 8'h00, 8'h08, 32'h04, 8'd2},        // R2
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h04, 32'h04, 8'd6},        // R6
    '{1'b1, 8'h10, 32'h81, 8'h00, 8'h08, 32'h85, 8'd2},        // R2 OR
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h18, 32'h00, 8'd7},        // R7
    '{1'b1, 8'h14, 32'h01, 8'h00, 8'h08, 32'h84, 8'd2},        // R2 clear
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h18, 32'h02, 8'd7},        // R7
    '{1'b1, 8'h0C, 32'h00, 8'h00, 8'h00, 32'h05, 8'd5},        // R5 zero ack
    '{1'b1, 8'h0C, 32'h04, 8'h00, 8'h00, 32'h01, 8'd5},        // R5
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h18, 32'hFFFF_FFFF, 8'd7}, // R7 none
    '{1'b0, 8'h00, 32'h00, 8'h10, 8'h00, 32'h01, 8'd8},        // R8 no latch
    '{1'b1, 8'h1C, 32'h02, 8'h10, 8'h1C, 32'h02, 8'd8},        // R8
    '{1'b0, 8'h00, 32'h00, 8'h10, 8'h00, 32'h11, 8'd4},        // R4 latch
    '{1'b1, 8'h00, 32'h80, 8'h10, 8'h00, 32'h11, 8'd9},        // R9 ignored
    '{1'b1, 8'h0C, 32'h10, 8'h10, 8'h00, 32'h01, 8'd4},        // R4 clear wins
    '{1'b0, 8'h00, 32'h00, 8'h10, 8'h00, 32'h11, 8'd4},        // R4 re-set
    '{1'b1, 8'h0C, 32'h10, 8'h00, 8'h00, 32'h01, 8'd4},        // R4
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h00, 32'h01, 8'd4},        // R4 stays clear
    '{1'b0, 8'h00, 32'h00, 8'h02, 8'h00, 32'h03, 8'd3},        // R3 edge
    '{1'b1, 8'h0C, 32'h02, 8'h02, 8'h00, 32'h01, 8'd3},        // R3 ack held
    '{1'b0, 8'h00, 32'h00, 8'h02, 8'h00, 32'h01, 8'd3},        // R3 no re-set
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h10, 32'h00, 8'd10},       // R10 write-only
    '{1'b1, 8'h40, 32'hFF, 8'h00, 8'h08, 32'h84, 8'd10},       // R10 unmapped write
    '{1'b0, 8'h00, 32'h00, 8'h00, 8'h20, 32'h00, 8'd10},       // R10 unmapped read
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 8'h00, 8'h08, 32'hFF, 8'd10},// R10 upper bits
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 8'h00, 8'h00, 32'h00, 8'd5}, // R5 all ones
    '{1'b1, 8'h08, 32'h00, 8'h00, 8'h04, 32'h00, 8'd2}         // R2 load zero
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic [31:0]     addr_i = '0;
  logic            wr_i = 1'b0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_vec_ctrl #(.NUM_SRC(NSRC), .EDGE_MASK(32'h0000_000F)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] d;
    @(negedge clk_i);
    rd(32'h00, d); check("R1 status in reset", d, 32'h0);
    rd(32'h18, d); check("R1 vector in reset", d, 32'hFFFF_FFFF);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    rd(32'h08, d); check("R1 enable after reset", d, 32'h0);
    rd(32'h1C, d); check("R1 ctrl after reset", d, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      src_i = VECS[i].src;
      addr_i = {24'h0, VECS[i].addr};
      wdata_i = VECS[i].wdata;
      wr_i = VECS[i].wr;
      @(posedge clk_i); @(negedge clk_i);
      wr_i = 1'b0;
      rd({24'h0, VECS[i].chk}, d);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // directed: output gating and priority
    wr(32'h08, 32'h48);
    src_i = 8'h08; tick(); src_i = 8'h00;
    check("R8 irq low without output enable", {31'b0, irq_o}, 32'h0);
    rd(32'h04, d); check("R6 pending edge 3", d, 32'h08);
    wr(32'h1C, 32'h03);
    check("R8 irq high with output enable", {31'b0, irq_o}, 32'h1);
    src_i = 8'h40; tick();
    rd(32'h18, d); check("R7 priority 3 over 6", d, 32'h3);
    wr(32'h0C, 32'h08);
    rd(32'h18, d); check("R7 next vector 6", d, 32'h6);
    check("R8 irq still high", {31'b0, irq_o}, 32'h1);
    wr(32'h14, 32'h40);
    check("R8 irq low after mask", {31'b0, irq_o}, 32'h0);
    rd(32'h18, d); check("R7 vector empty after mask", d, 32'hFFFF_FFFF);

    // mid-run reset
    rst_ni = 1'b0; #1;
    rd(32'h00, d); check("R1 status cleared by reset", d, 32'h0);
    rd(32'h1C, d); check("R1 ctrl cleared by reset", d, 32'h0);
    src_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    rd(32'h08, d); check("R1 enable cleared by reset", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule